// File: doc/BRIEF.md
# Paged Program Counter with Two-Slot Return Stack

This block is the instruction sequencer of a small controller whose 512-word program store is split into 8 pages of 64 words. It holds the 9-bit fetch address and a two-slot hardware return stack. It moves the address forward by one word each cycle unless an already decoded control code asks for a transfer. The transfers are a long jump, a jump inside the page, a call into the shared subroutine page, a long call, a return, and a return that also skips. There are also two two-cycle table operations that index the program store through a 4+4-bit index: an indirect jump and an indirect load into an 8-bit latch.

Page-relative work always uses the page of the address that follows the current one, PC+1. An operation in the last word of a page therefore acts on the next page. Pages 2 and 3 together form a single 128-word window for the in-page jump. A separate decoder supplies the control code, the operand byte, a full 9-bit target for the long forms, the two index nibbles, and a flag that marks the current instruction as skipped. The program store returns `rom_data` for whatever `fetch_addr` shows.

Top module: `pgseq_top`

## Requirements
- R1: While reset is low and in the first cycle after it, `fetch_addr` is 0, `skip_req` and `ind_busy` are 0, and `q_out` is 0. Both return slots hold 0, so a return right after reset goes to address 0.
- R2: In the normal case (code 0, or any unused code 9..15), the address goes up by one each cycle. It crosses page boundaries without a break and wraps from 511 to 0.
- R3: Code 1 (long jump) loads `long_tgt` in one cycle.
- R4: Code 2 (in-page jump) outside the window: let n = PC+1. When n[8:7] is not 01, the new address is {n[8:6], page_opnd[5:0]}, and the operand must carry 11 in bits [7:6].
- R5: Code 2 inside the window (n[8:7] = 01, pages 2 and 3): the new address is {n[8:7], page_opnd[6:0]}, and the operand must carry 1 in bit 7.
- R6: Code 3 (page call) pushes n = PC+1 and loads {3'b010, page_opnd[5:0]}. The operand carries 10 in bits [7:6]. It is not allowed when n lies in pages 2 or 3.
- R7: Code 4 (long call) pushes PC+2, which steps over its second byte, and loads `long_tgt`.
- R8: A push moves the top slot into the second slot and drops the old second value. Code 5 (return) loads the top slot into the address, and the second slot moves into the top slot while also keeping its own value.
- R9: Code 6 (return-and-skip) acts like code 5. It also raises `skip_req` for exactly the one cycle in which the return address is being fetched.
- R10: With no table operation in progress, a high `skip_cur` ignores the code. The address goes up by one and the stack does not change, so a skipped table operation costs one cycle.
- R11: Code 7 (indirect jump) spends one cycle with `ind_busy` = 1 and `fetch_addr` = {n[8], idx_a, idx_m}. The address then becomes {n[8], rom_data}.
- R12: Code 8 (indirect load) has the same busy cycle and address as code 7. `q_out` then takes `rom_data` and the address goes to PC+1. The top slot keeps its value and the second slot takes the old top value.
- R13: During the busy cycle of a table operation, `op_code` and `skip_cur` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 4 | Decoded control code of the current instruction |
| skip_cur | input | 1 | Current instruction is being skipped |
| page_opnd | input | 8 | Operand byte of the in-page jump or page call |
| long_tgt | input | 9 | Full target of the long jump or long call |
| idx_a | input | 4 | Upper index nibble for the table operations |
| idx_m | input | 4 | Lower index nibble for the table operations |
| rom_data | input | 8 | Program store byte at `fetch_addr` |
| fetch_addr | output | 9 | Program store address being fetched |
| skip_req | output | 1 | Asks the decoder to skip the instruction now fetched |
| ind_busy | output | 1 | Second cycle of a table operation |
| q_out | output | 8 | Latch loaded by the indirect load |

## Verification
An address register with a wrong value shows up on `fetch_addr` right after the next clock edge. The bench compares that address after every single cycle, so an error in any jump form is caught in the same step. A stack slot that is corrupted stays hidden until a return reads it, so the stack is checked by calling, overflowing and returning in chains, including the indirect load whose net effect only shows on the second return. The page selection is swept over the first, middle and last words of every page, because a decision based on PC instead of PC+1 differs only in the last word.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

   typedef enum logic [3:0] {
      OP_SEQ   = 4'd0,
      OP_JUMP  = 4'd1,
      OP_JPAGE = 4'd2,
      OP_CPAGE = 4'd3,
      OP_CALL  = 4'd4,
      OP_RET   = 4'd5,
      OP_RETSK = 4'd6,
      OP_IJMP  = 4'd7,
      OP_ILOAD = 4'd8
   } op_e;

   typedef enum logic [1:0] {
      IND_IDLE = 2'd0,
      IND_JUMP = 2'd1,
      IND_LOAD = 2'd2
   } ind_e;

endpackage

// File: rtl/pgseq_target.sv
module pgseq_target #(
   parameter int PC_W      = 9,
   parameter int PAGE_W    = 6,
   parameter bit WIDE_EN   = 1'b1,
   parameter int WIDE_PAGE = 2,
   parameter int SUB_PAGE  = 2
) (
   input  logic [PC_W-1:0]   nxt_pc,
   input  logic [PAGE_W+1:0] opnd,
   output logic [PC_W-1:0]   jp_addr,
   output logic [PC_W-1:0]   cp_addr,
   output logic              in_wide,
   output logic              jp_legal,
   output logic              cp_legal
);
   localparam int PG_W  = PC_W - PAGE_W;
   localparam int WIN_W = PC_W - PAGE_W - 1;
   localparam logic [PG_W-1:0] SUB_PG = PG_W'(SUB_PAGE);

   if (WIDE_EN) begin : g_wide
      localparam logic [WIN_W-1:0] WIN_ID = WIN_W'(WIDE_PAGE / 2);
      assign in_wide = (nxt_pc[PC_W-1:PAGE_W+1] == WIN_ID);
   end else begin : g_narrow
      assign in_wide = 1'b0;
   end

   always_comb begin
      if (in_wide) begin
         jp_addr  = {nxt_pc[PC_W-1:PAGE_W+1], opnd[PAGE_W:0]};
         jp_legal = opnd[PAGE_W+1];
      end else begin
         jp_addr  = {nxt_pc[PC_W-1:PAGE_W], opnd[PAGE_W-1:0]};
         jp_legal = (opnd[PAGE_W+1:PAGE_W] == 2'b11);
      end
   end

   assign cp_addr  = {SUB_PG, opnd[PAGE_W-1:0]};
   assign cp_legal = (opnd[PAGE_W+1:PAGE_W] == 2'b10) && !in_wide;

endmodule

// File: rtl/pgseq_stack.sv
module pgseq_stack #(
   parameter int W     = 9,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] push_val,
   output logic [W-1:0] top
);
   logic [W-1:0] ent   [DEPTH];
   logic [W-1:0] ent_d [DEPTH];

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         ent_d[i] = ent[i];
         if (push) begin
            ent_d[i] = (i == 0) ? push_val : ent[(i == 0) ? 0 : i-1];
         end else if (pop) begin
            ent_d[i] = (i == DEPTH-1) ? ent[i] : ent[(i == DEPTH-1) ? i : i+1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) ent[i] <= ent_d[i];
      end
   end

   assign top = ent[0];

   // R7/R8: a push makes the pushed value the top
   a_r7_push_top: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> top == $past(push_val));

   // R8: push and pop never together
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));

   if (DEPTH > 1) begin : g_deep
      // R8: pop brings the second slot up, bottom slot keeps its value
      a_r8_pop_up: assert property (@(posedge clk) disable iff (!rst_n)
         pop |=> top == $past(ent[1]));
      a_r8_bottom_keep: assert property (@(posedge clk) disable iff (!rst_n)
         pop |=> ent[DEPTH-1] == $past(ent[DEPTH-1]));
      // R8: push moves the old top down one slot
      a_r8_push_down: assert property (@(posedge clk) disable iff (!rst_n)
         push |=> ent[1] == $past(ent[0]));
   end

endmodule

// File: rtl/pgseq_top.sv
module pgseq_top
   import pgseq_pkg::*;
#(
   parameter int PC_W      = 9,
   parameter int PAGE_W    = 6,
   parameter int IDXA_W    = 4,
   parameter int IDXM_W    = 4,
   parameter int DEPTH     = 2,
   parameter bit WIDE_EN   = 1'b1,
   parameter int WIDE_PAGE = 2,
   parameter int SUB_PAGE  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [3:0]               op_code,
   input  logic                     skip_cur,
   input  logic [PAGE_W+1:0]        page_opnd,
   input  logic [PC_W-1:0]          long_tgt,
   input  logic [IDXA_W-1:0]        idx_a,
   input  logic [IDXM_W-1:0]        idx_m,
   input  logic [IDXA_W+IDXM_W-1:0] rom_data,
   output logic [PC_W-1:0]          fetch_addr,
   output logic                     skip_req,
   output logic                     ind_busy,
   output logic [IDXA_W+IDXM_W-1:0] q_out
);
   localparam int IDX_W = IDXA_W + IDXM_W;
   localparam int HI_W  = PC_W - IDX_W;
   localparam int PG_W  = PC_W - PAGE_W;
   localparam logic [PG_W-1:0] SUB_PG = PG_W'(SUB_PAGE);

   // elaboration-time parameter checks
   if (PAGE_W + 2 > PC_W) begin : g_bad_page
      $error("pgseq_top: PAGE_W too large for PC_W");
   end
   if (HI_W < 1) begin : g_bad_idx
      $error("pgseq_top: index must be narrower than PC_W");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("pgseq_top: DEPTH must be at least 1");
   end
   if (WIDE_EN && (WIDE_PAGE % 2 != 0)) begin : g_bad_win
      $error("pgseq_top: WIDE_PAGE must be even");
   end
   if (SUB_PAGE >= (1 << PG_W)) begin : g_bad_sub
      $error("pgseq_top: SUB_PAGE out of range");
   end

   op_e              op;
   ind_e             ind_q, ind_d;
   logic [PC_W-1:0]  pc_q, pc_d, ia_q, ia_d;
   logic [PC_W-1:0]  nxt, nxt2, jp_addr, cp_addr, push_val, stk_top;
   logic [IDX_W-1:0] q_q, q_d;
   logic             skr_q, skr_d, push, pop, active;
   logic             in_wide, jp_legal, cp_legal;

   assign op     = op_e'(op_code);
   assign nxt    = pc_q + PC_W'(1);
   assign nxt2   = pc_q + PC_W'(2);
   assign active = (ind_q == IND_IDLE) && !skip_cur;

   pgseq_target #(
      .PC_W(PC_W), .PAGE_W(PAGE_W), .WIDE_EN(WIDE_EN),
      .WIDE_PAGE(WIDE_PAGE), .SUB_PAGE(SUB_PAGE)
   ) u_target (
      .nxt_pc(nxt), .opnd(page_opnd), .jp_addr(jp_addr), .cp_addr(cp_addr),
      .in_wide(in_wide), .jp_legal(jp_legal), .cp_legal(cp_legal)
   );

   pgseq_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .push_val(push_val), .top(stk_top)
   );

   always_comb begin
      pc_d     = nxt;
      ind_d    = IND_IDLE;
      ia_d     = ia_q;
      skr_d    = 1'b0;
      q_d      = q_q;
      push     = 1'b0;
      pop      = 1'b0;
      push_val = nxt;
      case (ind_q)
         IND_JUMP: pc_d = {ia_q[PC_W-1:IDX_W], rom_data};
         IND_LOAD: begin
            q_d  = rom_data;
            pop  = 1'b1;
            pc_d = stk_top;
         end
         default: begin
            if (!skip_cur) begin
               case (op)
                  OP_JUMP:  pc_d = long_tgt;
                  OP_JPAGE: pc_d = jp_addr;
                  OP_CPAGE: begin
                     push = 1'b1;
                     pc_d = cp_addr;
                  end
                  OP_CALL: begin
                     push     = 1'b1;
                     push_val = nxt2;
                     pc_d     = long_tgt;
                  end
                  OP_RET: begin
                     pop  = 1'b1;
                     pc_d = stk_top;
                  end
                  OP_RETSK: begin
                     pop   = 1'b1;
                     pc_d  = stk_top;
                     skr_d = 1'b1;
                  end
                  OP_IJMP: begin
                     ind_d = IND_JUMP;
                     ia_d  = {nxt[PC_W-1:IDX_W], idx_a, idx_m};
                     pc_d  = pc_q;
                  end
                  OP_ILOAD: begin
                     ind_d = IND_LOAD;
                     ia_d  = {nxt[PC_W-1:IDX_W], idx_a, idx_m};
                     push  = 1'b1;
                     pc_d  = pc_q;
                  end
                  default: pc_d = nxt;
               endcase
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         ia_q  <= '0;
         ind_q <= IND_IDLE;
         skr_q <= 1'b0;
         q_q   <= '0;
      end else begin
         pc_q  <= pc_d;
         ia_q  <= ia_d;
         ind_q <= ind_d;
         skr_q <= skr_d;
         q_q   <= q_d;
      end
   end

   assign ind_busy   = (ind_q != IND_IDLE);
   assign fetch_addr = ind_busy ? ia_q : pc_q;
   assign skip_req   = skr_q;
   assign q_out      = q_q;

   // R2/R10: a skipped or plain step advances the fetch address by one
   a_r10_skip_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!ind_busy && skip_cur) |=> fetch_addr == PC_W'($past(fetch_addr) + 1));

   // R4/R5: in-page jump keeps the page (or window) of PC+1
   a_r4_jp_page: assert property (@(posedge clk) disable iff (!rst_n)
      (active && op == OP_JPAGE) |=> fetch_addr[PC_W-1:PAGE_W+1] == $past(nxt[PC_W-1:PAGE_W+1]));

   // R4/R5: operand encoding matches the page of PC+1
   a_r5_jp_encoding: assert property (@(posedge clk) disable iff (!rst_n)
      (active && op == OP_JPAGE) |-> jp_legal);

   // R6: page call lands in the subroutine page and is legal only outside the window
   a_r6_cp_page: assert property (@(posedge clk) disable iff (!rst_n)
      (active && op == OP_CPAGE) |=> fetch_addr[PC_W-1:PAGE_W] == SUB_PG);
   a_r6_cp_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (active && op == OP_CPAGE) |-> cp_legal);

   // R9: skip request only follows a return-and-skip
   a_r9_skip_origin: assert property (@(posedge clk) disable iff (!rst_n)
      skip_req |-> $past(active && op == OP_RETSK));

   // R11/R13: the busy cycle lasts exactly one cycle
   a_r11_busy_once: assert property (@(posedge clk) disable iff (!rst_n)
      ind_busy |=> !ind_busy);

   // R12: latch changes only at the end of an indirect load
   a_r12_q_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_q != IND_LOAD) |=> $stable(q_out));

endmodule

// File: tb/tb_pgseq_top.sv
`timescale 1ns/1ps
module tb_pgseq_top;
   localparam logic [3:0] C_SEQ = 4'd0, C_JUMP = 4'd1, C_JP = 4'd2, C_CP = 4'd3,
                          C_CALL = 4'd4, C_RET = 4'd5, C_RETSK = 4'd6,
                          C_IJMP = 4'd7, C_ILOAD = 4'd8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] op_code;
   logic       skip_cur;
   logic [7:0] page_opnd;
   logic [8:0] long_tgt;
   logic [3:0] idx_a, idx_m;
   logic [7:0] rom_data;
   logic [8:0] fetch_addr;
   logic       skip_req, ind_busy;
   logic [7:0] q_out;

   int n_chk = 0, n_bad = 0;
   int mpc = 0, msa = 0, msb = 0;
   bit done = 0;

   always #10 clk = ~clk;

   function automatic logic [7:0] rb(input int x);
      return 8'((x * 37 + 11) & 255);
   endfunction

   assign rom_data = rb(int'(fetch_addr));

   pgseq_top dut (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .skip_cur(skip_cur),
      .page_opnd(page_opnd), .long_tgt(long_tgt), .idx_a(idx_a), .idx_m(idx_m),
      .rom_data(rom_data), .fetch_addr(fetch_addr), .skip_req(skip_req),
      .ind_busy(ind_busy), .q_out(q_out)
   );

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic cyc(input logic [3:0] op, input logic [7:0] opn, input logic [8:0] tgt,
                      input logic [3:0] a, input logic [3:0] m, input logic sk);
      op_code = op; page_opnd = opn; long_tgt = tgt; idx_a = a; idx_m = m; skip_cur = sk;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_seq(input string req, input logic [3:0] op);
      cyc(op, 8'h00, 9'd0, 4'd0, 4'd0, 1'b0);
      mpc = (mpc + 1) % 512;
      chk(req, int'(fetch_addr), mpc);
   endtask

   task automatic t_jump(input int tgt);
      cyc(C_JUMP, 8'h00, 9'(tgt), 4'd0, 4'd0, 1'b0);
      mpc = tgt;
      chk("R3", int'(fetch_addr), mpc);
   endtask

   task automatic t_jp(input logic [7:0] opn);
      int n = (mpc + 1) % 512;
      bit win = ((n >> 7) == 1);
      mpc = win ? ((n & 384) | (int'(opn) & 127)) : ((n & 448) | (int'(opn) & 63));
      cyc(C_JP, opn, 9'd0, 4'd0, 4'd0, 1'b0);
      chk(win ? "R5" : "R4", int'(fetch_addr), mpc);
   endtask

   task automatic t_cp(input logic [7:0] opn);
      msb = msa; msa = (mpc + 1) % 512;
      mpc = 128 | (int'(opn) & 63);
      cyc(C_CP, opn, 9'd0, 4'd0, 4'd0, 1'b0);
      chk("R6", int'(fetch_addr), mpc);
   endtask

   task automatic t_call(input int tgt);
      msb = msa; msa = (mpc + 2) % 512;
      mpc = tgt;
      cyc(C_CALL, 8'h00, 9'(tgt), 4'd0, 4'd0, 1'b0);
      chk("R7", int'(fetch_addr), mpc);
   endtask

   task automatic t_ret(input bit sk);
      mpc = msa; msa = msb;
      cyc(sk ? C_RETSK : C_RET, 8'h00, 9'd0, 4'd0, 4'd0, 1'b0);
      chk(sk ? "R9" : "R8", int'(fetch_addr), mpc);
      chk("R9", int'(skip_req), int'(sk));
      if (sk) begin
         // decoder skips the instruction at the return address
         cyc(C_JUMP, 8'h00, 9'd3, 4'd0, 4'd0, 1'b1);
         mpc = (mpc + 1) % 512;
         chk("R9", int'(fetch_addr), mpc);
         chk("R9", int'(skip_req), 0);
      end
   endtask

   task automatic t_skipped(input logic [3:0] op);
      cyc(op, 8'h80, 9'd77, 4'd5, 4'd6, 1'b1);
      mpc = (mpc + 1) % 512;
      chk("R10", int'(fetch_addr), mpc);
      chk("R10", int'(ind_busy), 0);
   endtask

   task automatic t_ijmp(input int a, input int m);
      int n = (mpc + 1) % 512;
      int ia = (n & 256) | (a << 4) | m;
      cyc(C_IJMP, 8'h00, 9'd0, 4'(a), 4'(m), 1'b0);
      chk("R11", int'(fetch_addr), ia);
      chk("R11", int'(ind_busy), 1);
      // R13: code and skip flag are ignored in the busy cycle
      cyc(C_JUMP, 8'h00, 9'd9, 4'd0, 4'd0, 1'b1);
      mpc = (n & 256) | int'(rb(ia));
      chk("R11", int'(fetch_addr), mpc);
      chk("R13", int'(ind_busy), 0);
   endtask

   task automatic t_iload(input int a, input int m);
      int n = (mpc + 1) % 512;
      int ia = (n & 256) | (a << 4) | m;
      cyc(C_ILOAD, 8'h00, 9'd0, 4'(a), 4'(m), 1'b0);
      chk("R12", int'(fetch_addr), ia);
      chk("R12", int'(ind_busy), 1);
      cyc(C_CALL, 8'h00, 9'd9, 4'd0, 4'd0, 1'b1);
      msb = msa; mpc = n;
      chk("R12", int'(q_out), int'(rb(ia)));
      chk("R12", int'(fetch_addr), mpc);
      chk("R13", int'(ind_busy), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; op_code = C_SEQ; skip_cur = 1'b0; page_opnd = 8'h00;
      long_tgt = 9'd0; idx_a = 4'd0; idx_m = 4'd0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", int'(fetch_addr), 0);
      chk("R1", int'(skip_req), 0);
      chk("R1", int'(ind_busy), 0);
      chk("R1", int'(q_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      mpc = 1;
      chk("R1", int'(fetch_addr), 1);
      // R1: empty slots return to 0
      t_ret(1'b0);
      chk("R1", int'(fetch_addr), 0);

      // R2: sequential, page crossing, wrap, unused codes
      for (int i = 0; i < 4; i++) t_seq("R2", C_SEQ);
      t_jump(62);
      for (int i = 0; i < 3; i++) t_seq("R2", C_SEQ);
      t_jump(511);
      t_seq("R2", C_SEQ);
      for (int c = 9; c < 16; c++) t_seq("R2", 4'(c));

      // R3: long jump sweep
      for (int t = 0; t < 512; t += 37) t_jump(t);

      // R4/R5: in-page jump from first, middle, second-last, last word of each page
      for (int p = 0; p < 8; p++) begin
         for (int k = 0; k < 4; k++) begin
            int off = (k == 0) ? 0 : (k == 1) ? 17 : (k == 2) ? 62 : 63;
            int addr = p * 64 + off;
            int n = (addr + 1) % 512;
            t_jump(addr);
            if ((n >> 7) == 1) t_jp(8'(128 | ((addr * 5) & 127)));
            else               t_jp(8'(192 | ((addr * 5) & 63)));
         end
      end

      // R6: page call then return, including last words of pages
      for (int p = 0; p < 8; p++) begin
         for (int k = 0; k < 2; k++) begin
            int addr = p * 64 + ((k == 0) ? 5 : 63);
            int n = (addr + 1) % 512;
            if ((n >> 7) != 1) begin
               t_jump(addr);
               t_cp(8'(128 | ((addr * 3) & 63)));
               t_ret(1'b0);
            end
         end
      end

      // R7: long call, return address steps over second byte and wraps
      t_jump(510);
      t_call(165);
      t_ret(1'b0);
      chk("R7", int'(fetch_addr), 0);

      // R8: three calls on two slots, then three returns
      t_jump(10);
      t_call(100);
      t_call(200);
      t_call(300);
      t_ret(1'b0);
      chk("R8", int'(fetch_addr), 202);
      t_ret(1'b0);
      chk("R8", int'(fetch_addr), 102);
      t_ret(1'b0);
      chk("R8", int'(fetch_addr), 102);

      // R9: return-and-skip
      t_jump(20);
      t_call(50);
      t_ret(1'b1);

      // R10: skipped instructions of every kind, stack untouched
      t_jump(30);
      t_call(70);
      t_skipped(C_JUMP);
      t_skipped(C_CALL);
      t_skipped(C_CP);
      t_skipped(C_RET);
      t_skipped(C_IJMP);
      t_skipped(C_ILOAD);
      t_ret(1'b0);
      chk("R10", int'(fetch_addr), 32);

      // R11: indirect jump, full index sweep from three places
      for (int b = 0; b < 3; b++) begin
         for (int a = 0; a < 16; a++) begin
            for (int m = 0; m < 16; m++) begin
               t_jump((b == 0) ? 64 : (b == 1) ? 255 : 451);
               t_ijmp(a, m);
            end
         end
      end

      // R12: indirect load, latch and net stack effect
      t_jump(5);
      t_call(300);
      for (int a = 0; a < 16; a += 3) begin
         for (int m = 0; m < 16; m += 5) begin
            t_jump((a & 1) ? 255 : 140);
            t_iload(a, m);
         end
      end
      t_ret(1'b0);
      chk("R12", int'(fetch_addr), 7);
      t_ret(1'b0);
      chk("R12", int'(fetch_addr), 7);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule